// File: doc/BRIEF.md
# Unsigned Add/Subtract/Shift Execution Unit

This block performs one arithmetic or logical-shift operation on two unsigned operands. A requester raises `start_i` for one cycle and presents a 4-bit command with two operands at the same time. One clock later the unit raises `done_o` for a single cycle. In that cycle it presents a 2-bit response code and the result.

Four command codes are legal: 1 adds, 2 subtracts the second operand from the first, 5 shifts the first operand left and 6 shifts it right. Code 0 is a no-op and produces no response. Every other code is rejected. An unsigned carry-out on an add or a borrow on a subtract is reported as an error and is not returned as a wrapped value.

Top module: `calc_exec_unit`

## Requirements
- R1: While reset is held and in the cycles after it until the first start, `done_o` is 0, `resp_o` is 0 and `result_o` is 0.
- R2: Command 1 with no carry out of the top bit gives response 1 (success) and `result_o` = opa + opb.
- R3: Command 1 whose unsigned sum does not fit in the data width gives response 2 (error) and `result_o` = 0.
- R4: Command 2 with opb <= opa gives response 1 and `result_o` = opa - opb.
- R5: Command 2 with opb > opa gives response 2 and `result_o` = 0.
- R6: Command 5 gives response 1 and opa shifted left, zero-filled, by the value of opb bits [4:0]. The upper bits of opb are ignored and bits shifted out raise no error.
- R7: Command 6 gives response 1 and opa shifted right logically, zero-filled, by the value of opb bits [4:0]. The upper bits of opb are ignored.
- R8: Commands 3, 4 and 7 through 15 give response 2 and `result_o` = 0.
- R9: Command 0 with `start_i` produces no `done_o` pulse, and the outputs stay at 0.
- R10: A start with a non-zero command makes `done_o` high exactly one cycle later, for one cycle per start, back-to-back starts included. While `done_o` is low, `resp_o` and `result_o` are 0.
- R11: Response 3 (internal error) is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Operation request strobe |
| cmd_i | input | 4 | Command code |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand (its low 5 bits give the shift amount) |
| done_o | output | 1 | Single-cycle completion pulse |
| result_o | output | 32 | Result, valid with `done_o` |
| resp_o | output | 2 | 0 none, 1 success, 2 invalid command or overflow/underflow, 3 internal error |

## Verification
The hardest cases to reach are the edges of the carry and borrow boundaries: a sum of exactly all-ones must succeed, and one more must fail. Random operands almost never land there. The stimulus walks pairs whose sum straddles the top of the range. It also crosses a set of extreme operand values with all sixteen command codes. Shift sweeps set garbage in the upper bits of the second operand so that any use of those bits shows up. Back-to-back starts and interleaved idle cycles test the single-cycle pulse and the zeroed idle outputs.

// File: rtl/calc_pkg.sv
package calc_pkg;
  localparam int unsigned CALC_DW  = 32;
  localparam int unsigned CALC_CW  = 4;
  localparam int unsigned CALC_SW  = $clog2(CALC_DW);

  localparam logic [CALC_CW-1:0] CMD_NOP = 4'd0;
  localparam logic [CALC_CW-1:0] CMD_ADD = 4'd1;
  localparam logic [CALC_CW-1:0] CMD_SUB = 4'd2;
  localparam logic [CALC_CW-1:0] CMD_SHL = 4'd5;
  localparam logic [CALC_CW-1:0] CMD_SHR = 4'd6;

  typedef enum logic [1:0] {
    RSP_NONE     = 2'd0,
    RSP_OK       = 2'd1,
    RSP_ERR      = 2'd2,
    RSP_INTERNAL = 2'd3
  } rsp_e;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_ADD,
    OP_SUB,
    OP_SHL,
    OP_SHR,
    OP_BAD
  } op_e;
endpackage

// File: rtl/calc_rst_sync.sv
module calc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/calc_decode.sv
module calc_decode
  import calc_pkg::*;
(
  input  logic [CALC_CW-1:0] cmd_i,
  output op_e                op_o
);
  always_comb begin
    unique case (cmd_i)
      CMD_NOP: op_o = OP_NOP;
      CMD_ADD: op_o = OP_ADD;
      CMD_SUB: op_o = OP_SUB;
      CMD_SHL: op_o = OP_SHL;
      CMD_SHR: op_o = OP_SHR;
      default: op_o = OP_BAD;
    endcase
  end
endmodule

// File: rtl/calc_arith.sv
module calc_arith #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          fault_o
);
  logic [DW:0] sum_w;
  logic [DW:0] diff_w;

  always_comb begin
    sum_w  = {1'b0, a_i} + {1'b0, b_i};
    diff_w = {1'b0, a_i} - {1'b0, b_i};
    if (sub_i) begin
      res_o   = diff_w[DW-1:0];
      fault_o = diff_w[DW];
    end else begin
      res_o   = sum_w[DW-1:0];
      fault_o = sum_w[DW];
    end
  end

  // R3 / R5: a clean result never wraps past its first operand
  always_comb begin
    if (!fault_o && !sub_i)
      p_no_overflow_r3: assert (res_o >= a_i);
    if (!fault_o && sub_i)
      p_no_underflow_r5: assert (res_o <= a_i);
  end
endmodule

// File: rtl/calc_shift.sv
module calc_shift #(
  parameter int unsigned DW = 32,
  localparam int unsigned SW = $clog2(DW)
) (
  input  logic [DW-1:0] a_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    if (left_i) res_o = a_i << amt_i;
    else        res_o = a_i >> amt_i;
  end
endmodule

// File: rtl/calc_exec_unit.sv
module calc_exec_unit
  import calc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CALC_CW-1:0] cmd_i,
  input  logic [CALC_DW-1:0] opa_i,
  input  logic [CALC_DW-1:0] opb_i,
  output logic               done_o,
  output logic [CALC_DW-1:0] result_o,
  output logic [1:0]         resp_o
);
  logic               rst_n;
  op_e                op_w;
  logic [CALC_DW-1:0] arith_res;
  logic               arith_fault;
  logic [CALC_DW-1:0] shift_res;

  logic               done_d, done_q;
  logic [CALC_DW-1:0] res_d, res_q;
  rsp_e               rsp_d, rsp_q;
  logic               load_en;

  calc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n)
  );

  calc_decode u_dec (.cmd_i(cmd_i), .op_o(op_w));

  calc_arith #(.DW(CALC_DW)) u_arith (
    .a_i(opa_i), .b_i(opb_i), .sub_i(op_w == OP_SUB),
    .res_o(arith_res), .fault_o(arith_fault)
  );

  calc_shift #(.DW(CALC_DW)) u_shift (
    .a_i(opa_i), .amt_i(opb_i[CALC_SW-1:0]), .left_i(op_w == OP_SHL),
    .res_o(shift_res)
  );

  // next state
  always_comb begin
    done_d = 1'b0;
    res_d  = '0;
    rsp_d  = RSP_NONE;
    if (start_i) begin
      unique case (op_w)
        OP_NOP: ;
        OP_ADD, OP_SUB: begin
          done_d = 1'b1;
          if (arith_fault) rsp_d = RSP_ERR;
          else begin
            rsp_d = RSP_OK;
            res_d = arith_res;
          end
        end
        OP_SHL, OP_SHR: begin
          done_d = 1'b1;
          rsp_d  = RSP_OK;
          res_d  = shift_res;
        end
        default: begin
          done_d = 1'b1;
          rsp_d  = RSP_ERR;
        end
      endcase
    end
  end

  assign load_en = start_i | done_q;

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      res_q  <= '0;
      rsp_q  <= RSP_NONE;
    end else if (load_en) begin
      done_q <= done_d;
      res_q  <= res_d;
      rsp_q  <= rsp_d;
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;
  assign resp_o   = rsp_q;

  p_done_follows_start_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_i && cmd_i != CMD_NOP) |=> done_o);
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !done_o |-> (resp_o == 2'd0 && result_o == '0));
  p_no_start_no_done_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !start_i |=> !done_o);
  p_noop_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_i && cmd_i == CMD_NOP) |=> !done_o);
  p_bad_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_i && op_w == OP_BAD) |=> (resp_o == 2'd2 && result_o == '0));
  p_no_internal_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    resp_o != 2'd3);
  p_err_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (resp_o == 2'd2) |-> (result_o == '0));
endmodule

// File: tb/calc_exec_unit_tb.sv
`timescale 1ns/1ps
module calc_exec_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i;
  logic [3:0]  cmd_i;
  logic [31:0] opa_i, opb_i;
  logic        done_o;
  logic [31:0] result_o;
  logic [1:0]  resp_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  calc_exec_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cmd_i(cmd_i),
    .opa_i(opa_i), .opb_i(opb_i), .done_o(done_o), .result_o(result_o),
    .resp_o(resp_o)
  );

  task automatic check(input string req, input logic d, input logic [1:0] r,
                       input logic [31:0] v);
    checks++;
    if (done_o !== d || resp_o !== r || result_o !== v) begin
      failures++;
      $display("FAIL %s: got done=%0b resp=%0d result=%h, expected done=%0b resp=%0d result=%h",
               req, done_o, resp_o, result_o, d, r, v);
    end
  endtask

  // run one operation; called at a negedge, returns at the next negedge after checking
  task automatic run_op(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    logic [32:0] wide;
    logic        ed;
    logic [1:0]  er;
    logic [31:0] ev;
    string       tag;
    ed = 1'b1; er = 2'd1; ev = '0;
    case (c)
      4'd0: begin ed = 1'b0; er = 2'd0; tag = "R9"; end
      4'd1: begin
        wide = {1'b0, a} + {1'b0, b};
        if (wide[32]) begin er = 2'd2; tag = "R3"; end
        else begin ev = wide[31:0]; tag = "R2"; end
      end
      4'd2: begin
        if (b > a) begin er = 2'd2; tag = "R5"; end
        else begin ev = a - b; tag = "R4"; end
      end
      4'd5: begin ev = a << (b % 32); tag = "R6"; end
      4'd6: begin ev = a >> (b % 32); tag = "R7"; end
      default: begin er = 2'd2; tag = "R8"; end
    endcase
    start_i = 1'b1; cmd_i = c; opa_i = a; opb_i = b;
    @(negedge clk_i);
    start_i = 1'b0; cmd_i = '0; opa_i = '0; opb_i = '0;
    check(tag, ed, er, ev);
    if (resp_o === 2'd3) check("R11", 1'b0, 2'd0, 32'h0);
  endtask

  task automatic idle_check();
    @(negedge clk_i);
    check("R10", 1'b0, 2'd0, 32'h0);
  endtask

  logic [31:0] corners [8] = '{32'h0, 32'h1, 32'h2, 32'h7fff_ffff,
                               32'h8000_0000, 32'hffff_ffff, 32'h1234_5678, 32'hffff_fffe};

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; cmd_i = '0; opa_i = '0; opb_i = '0;
    repeat (3) @(negedge clk_i);
    check("R1", 1'b0, 2'd0, 32'h0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1", 1'b0, 2'd0, 32'h0);

    // corner crossing with every command, back to back
    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op(c[3:0], corners[i], corners[j]);
      idle_check();
    end

    // carry boundary: sum exactly all-ones vs one beyond
    for (int k = 0; k < 64; k++) begin
      run_op(4'd1, 32'hffff_ffff - k, k);
      run_op(4'd1, 32'hffff_ffff - k, k + 1);
      run_op(4'd2, k, k);
      run_op(4'd2, k, k + 1);
    end
    idle_check();

    // shifts: every amount, upper bits of opb filled with noise (R6, R7)
    for (int s = 0; s < 32; s++) begin
      run_op(4'd5, 32'h8000_0001, {27'h5a5_a5a5 ^ 27'(s * 977), 5'(s)});
      run_op(4'd6, 32'h8000_0001, {27'h7ff_ffff, 5'(s)});
      run_op(4'd5, 32'ha5a5_3c3c, {27'(s), 5'(s)});
      run_op(4'd6, 32'ha5a5_3c3c, {27'h123_4567, 5'(s)});
      idle_check();
    end

    // no-op between two real operations
    run_op(4'd1, 32'd5, 32'd7);
    run_op(4'd0, 32'd9, 32'd9);
    run_op(4'd2, 32'd9, 32'd4);
    idle_check();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule